// File: doc/BRIEF.md
# Dual-Channel Output Compare Unit

This block sits next to a free-running timer. It watches the timer's count value and compares it against two compare registers that the CPU can write. When the count equals a channel's register, the channel raises its compare flag. The flag is not raised at once: it is raised at the edge that ends the timer tick during which the equality was present. A flag can drive an interrupt request when that channel's enable is set. The flag is lowered by the interrupt acknowledge or by a software write-one-to-clear.

Each channel also drives one waveform pin. On a match, the pin either keeps its level, toggles, goes low or goes high, as its 2-bit compare-output mode selects. Count, tick and mode come from the surrounding timer and its control logic. The block holds only the compare registers, the flags and the pin levels.

Top module: `oc_dual_compare`

## Requirements
- R1: While rst_n is low, at a rising clock edge every flag, every waveform pin and both compare registers become 0.
- R2: At a clock edge with wr_en high, the compare register of channel wr_sel (0 = channel 0, 1 = channel 1) loads wr_data. The other register is unchanged.
- R3: A channel's flag is set at a rising edge only when tick is high and count equals that channel's compare register during that cycle. With tick low, no flag is set, whatever the count.
- R4: irq[i] is high exactly when flag[i] and irq_en[i] are both high.
- R5: At an edge with irq_ack[i] high, flag[i] is cleared.
- R6: At an edge with clr_wr high, each flag whose bit in clr_mask is 1 is cleared. Flags whose mask bit is 0 keep their value.
- R7: When a set (R3) and a clear (R5 or R6) of the same flag occur at the same edge, the flag ends up set.
- R8: At an edge with tick high and a match on channel i, wave[i] follows com_mode[2i+1:2i]: 00 keeps its level, 01 toggles, 10 becomes 0, 11 becomes 1. With tick low or no match, wave[i] keeps its level.
- R9: A compare register write at the same edge as a tick is compared using the old register value. The new value takes effect from the next cycle.
- R10: The two channels are independent. A match, clear or register write on one channel does not change the other channel's flag or pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer tick enable; the count advances at edges where this is high |
| count | input | 8 | Current timer count |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 1 | Channel selected for the write |
| wr_data | input | 8 | Compare value to write |
| clr_wr | input | 1 | Write-one-to-clear strobe for the flags |
| clr_mask | input | 2 | Per-channel ones that clear flags |
| irq_en | input | 2 | Per-channel interrupt enable |
| irq_ack | input | 2 | Per-channel interrupt acknowledge |
| com_mode | input | 4 | Compare-output mode, 2 bits per channel, channel 0 in bits 1:0 |
| flag | output | 2 | Compare flags |
| irq | output | 2 | Interrupt requests |
| wave | output | 2 | Waveform pins |

## Verification
The hardest situations to reach from the ports are edges where two events collide on one channel. One is a new match arriving in the same cycle as an acknowledge or a write-one-to-clear. The other is a compare register being rewritten at the very edge where the old value matches. The vector table sets up each collision on purpose: it puts the register value and the count in place first, then fires the match together with the clear or the write. The waveform pin is set to toggle, so each evaluated match leaves a visible trace on the pin. A mid-run reset followed by a tick at count zero shows that the compare registers returned to zero.

// File: rtl/oc_pkg.sv
// Shared types for the dual-channel output compare unit.
// Assumes: mode encoding is fixed by the requirements and decoded only by oc_wave.
package oc_pkg;

    typedef enum logic [1:0] {
        COM_HOLD   = 2'b00,
        COM_TOGGLE = 2'b01,
        COM_CLEAR  = 2'b10,
        COM_SET    = 2'b11
    } com_mode_e;

endpackage

// File: rtl/oc_cmp_reg.sv
// Compare register with equality detector for one channel.
// Assumes: the match reflects the register value held before any write at this edge.
module oc_cmp_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic [W-1:0] count,
    output logic         match
);

    logic [W-1:0] cmp_q;

    // Hold the CPU-written compare value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (load)
            cmp_q <= din;
    end

    // Continuous equality between the count and the stored value.
    always_comb match = (count == cmp_q);

endmodule

// File: rtl/oc_flag.sv
// Compare flag bit: set by a qualified match, cleared by acknowledge or write-one.
// Assumes: set has priority over clear at the same edge.
module oc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Update the flag with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

endmodule

// File: rtl/oc_wave.sv
// Waveform pin driver for one channel, acting on qualified matches only.
// Assumes: fire is already gated by the timer tick.
module oc_wave
    import oc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fire,
    input  com_mode_e mode,
    output logic      wave
);

    logic wave_nx;

    // Choose the next pin level from the compare-output mode.
    always_comb begin
        wave_nx = wave;
        if (fire) begin
            unique case (mode)
                COM_HOLD:   wave_nx = wave;
                COM_TOGGLE: wave_nx = ~wave;
                COM_CLEAR:  wave_nx = 1'b0;
                COM_SET:    wave_nx = 1'b1;
                default:    wave_nx = wave;
            endcase
        end
    end

    // Register the pin level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave <= 1'b0;
        else
            wave <= wave_nx;
    end

endmodule

// File: rtl/oc_dual_compare.sv
// Output compare unit with NCH independent channels watching one timer count.
// Assumes: count and tick come from the same clock domain; tick marks count updates.
module oc_dual_compare
    import oc_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int W     = 8,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [W-1:0]     count,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             clr_wr,
    input  logic [NCH-1:0]   clr_mask,
    input  logic [NCH-1:0]   irq_en,
    input  logic [NCH-1:0]   irq_ack,
    input  logic [2*NCH-1:0] com_mode,
    output logic [NCH-1:0]   flag,
    output logic [NCH-1:0]   irq,
    output logic [NCH-1:0]   wave
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic ld;
        logic hit;
        logic fire;
        logic clr;

        // Decode the register write, qualify the match, and gather clears.
        always_comb begin
            ld   = wr_en && (wr_sel == SEL_W'(i));
            fire = tick && hit;
            clr  = irq_ack[i] || (clr_wr && clr_mask[i]);
        end

        oc_cmp_reg #(.W(W)) u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ld),
            .din   (wr_data),
            .count (count),
            .match (hit)
        );

        oc_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (fire),
            .clr   (clr),
            .flag  (flag[i])
        );

        oc_wave u_wave (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (fire),
            .mode  (com_mode_e'(com_mode[2*i +: 2])),
            .wave  (wave[i])
        );

        // Gate the flag with its interrupt enable.
        always_comb irq[i] = flag[i] && irq_en[i];
    end

endmodule

// File: rtl/oc_dual_compare_chk.sv
// Checker for oc_dual_compare: port-level temporal properties per channel.
// Assumes: attached through the bind below; reset is synchronous active-low.
module oc_dual_compare_chk #(
    parameter int NCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             clr_wr,
    input logic [NCH-1:0]   clr_mask,
    input logic [NCH-1:0]   irq_ack,
    input logic [2*NCH-1:0] com_mode,
    input logic [NCH-1:0]   flag,
    input logic [NCH-1:0]   irq,
    input logic [NCH-1:0]   wave
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R3: a flag can only rise after a tick cycle
        a_r3_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(tick));

        // R4: a request never appears without its flag
        a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> flag[i]);

        // R5: acknowledge without a tick leaves the flag low
        a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[i] && !tick) |=> !flag[i]);

        // R6: write-one-to-clear without a tick leaves the flag low
        a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_mask[i] && !tick) |=> !flag[i]);

        // R8: pin is quiet on non-tick cycles
        a_r8_wave_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> $stable(wave[i]));

        // R8: hold mode never moves the pin
        a_r8_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
            (com_mode[2*i +: 2] == 2'b00) |=> $stable(wave[i]));
    end

endmodule

bind oc_dual_compare oc_dual_compare_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clr_wr   (clr_wr),
    .clr_mask (clr_mask),
    .irq_ack  (irq_ack),
    .com_mode (com_mode),
    .flag     (flag),
    .irq      (irq),
    .wave     (wave)
);

// File: tb/tb_oc_dual_compare.sv
module tb_oc_dual_compare;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [7:0] count;
    logic       wr_en;
    logic [0:0] wr_sel;
    logic [7:0] wr_data;
    logic       clr_wr;
    logic [1:0] clr_mask;
    logic [1:0] irq_en;
    logic [1:0] irq_ack;
    logic [3:0] com_mode;
    logic [1:0] flag;
    logic [1:0] irq;
    logic [1:0] wave;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    oc_dual_compare dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .irq_en(irq_en),
        .irq_ack(irq_ack), .com_mode(com_mode),
        .flag(flag), .irq(irq), .wave(wave)
    );

    typedef struct packed {
        logic       tk;
        logic [7:0] cnt;
        logic       we;
        logic       ws;
        logic [7:0] wd;
        logic       cw;
        logic [1:0] cm;
        logic [1:0] ie;
        logic [1:0] ak;
        logic [1:0] ma;
        logic [1:0] mb;
        logic [1:0] ef;
        logic [1:0] ei;
        logic [1:0] ew;
    } vec_t;

    localparam int NV = 14;
    // Each row: inputs for one cycle, then expected flag/irq/wave after that edge.
    localparam vec_t VEC [NV] = '{
        //  tk  cnt   we  ws  wd    cw  cm     ie     ak     ma     mb     ef     ei     ew
        '{1'b0, 8'd0, 1'b1, 1'b0, 8'd5, 1'b0, 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 2'b00, 2'b00}, // R2 R3
        '{1'b0, 8'd0, 1'b1, 1'b1, 8'd9, 1'b0, 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 2'b00, 2'b00}, // R2
        '{1'b1, 8'd4, 1'b0, 1'b0, 8'd0, 1'b0, 2'b00, 2'b01, 2'b00, 2'b01, 2'b10, 2'b00, 2'b00, 2'b00}, // R3 no match
        '{1'b1, 8'd5, 1'b0, 1'b0, 8'd0, 1'b0, 2'b00, 2'b01, 2'b00, 2'b01, 2'b10, 2'b01, 2'b01, 2'b01}, // R3 R4 R8 toggle
        '{1'b0, 8'd5, 1'b0, 1'b0, 8'd0, 1'b0, 2'b00, 2'b01, 2'b01, 2'b01, 2'b10, 2'b00, 2'b00, 2'b01}, // R5
        '{1'b1, 8'd9, 1'b0, 1'b0, 8'd0, 1'b0, 2'b00, 2'b11, 2'b00, 2'b01, 2'b10, 2'b10, 2'b10, 2'b01}, // R8 clear R10
        '{1'b0, 8'd9, 1'b0, 1'b0, 8'd0, 1'b1, 2'b01, 2'b11, 2'b00, 2'b01, 2'b10, 2'b10, 2'b10, 2'b01}, // R6 mask 0 kept
        '{1'b0, 8'd9, 1'b0, 1'b0, 8'd0, 1'b1, 2'b10, 2'b11, 2'b00, 2'b01, 2'b10, 2'b00, 2'b00, 2'b01}, // R6
        '{1'b1, 8'd9, 1'b0, 1'b0, 8'd0, 1'b1, 2'b10, 2'b00, 2'b00, 2'b01, 2'b11, 2'b10, 2'b00, 2'b11}, // R7 R8 set
        '{1'b1, 8'd5, 1'b0, 1'b0, 8'd0, 1'b0, 2'b00, 2'b11, 2'b00, 2'b01, 2'b11, 2'b11, 2'b11, 2'b10}, // R8 toggle back
        '{1'b1, 8'd5, 1'b0, 1'b0, 8'd0, 1'b0, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 2'b01, 2'b00, 2'b10}, // R7 R5 R8 hold
        '{1'b1, 8'd5, 1'b1, 1'b0, 8'd7, 1'b0, 2'b00, 2'b00, 2'b00, 2'b01, 2'b11, 2'b01, 2'b00, 2'b11}, // R9 old value
        '{1'b1, 8'd5, 1'b0, 1'b0, 8'd0, 1'b0, 2'b00, 2'b00, 2'b00, 2'b01, 2'b11, 2'b01, 2'b00, 2'b11}, // R9 new value
        '{1'b1, 8'd7, 1'b0, 1'b0, 8'd0, 1'b0, 2'b00, 2'b00, 2'b00, 2'b01, 2'b11, 2'b01, 2'b00, 2'b10}  // R9 R10
    };

    task automatic idle_inputs();
        tick = 1'b0; count = 8'd0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'd0;
        clr_wr = 1'b0; clr_mask = 2'b00; irq_en = 2'b00; irq_ack = 2'b00; com_mode = 4'b0000;
    endtask

    task automatic check2(input string req, input string what,
                          input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: reset state
        check2("R1", "flag", flag, 2'b00);
        check2("R1", "wave", wave, 2'b00);
        check2("R1", "irq",  irq,  2'b00);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            tick = VEC[v].tk; count = VEC[v].cnt; wr_en = VEC[v].we; wr_sel = VEC[v].ws;
            wr_data = VEC[v].wd; clr_wr = VEC[v].cw; clr_mask = VEC[v].cm;
            irq_en = VEC[v].ie; irq_ack = VEC[v].ak; com_mode = {VEC[v].mb, VEC[v].ma};
            @(negedge clk);
            check2($sformatf("R3/R5-R10 vec%0d", v), "flag", flag, VEC[v].ef);
            check2($sformatf("R4 vec%0d", v),        "irq",  irq,  VEC[v].ei);
            check2($sformatf("R8 vec%0d", v),        "wave", wave, VEC[v].ew);
        end

        // R1: mid-run reset clears pins, flags and compare registers
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        check2("R1", "flag after reset", flag, 2'b00);
        check2("R1", "wave after reset", wave, 2'b00);
        rst_n = 1'b1;
        // Both registers back at zero: tick at count 0 with set mode matches both
        tick = 1'b1; count = 8'd0; com_mode = 4'b1111; irq_en = 2'b11;
        @(negedge clk);
        check2("R1", "flag from zeroed registers", flag, 2'b11);
        check2("R1", "wave from zeroed registers", wave, 2'b11);
        check2("R4", "irq both enabled", irq, 2'b11);

        // R3: count equal but tick low sets nothing after clearing
        idle_inputs();
        clr_wr = 1'b1; clr_mask = 2'b11;
        @(negedge clk);
        check2("R6", "clear both", flag, 2'b00);
        clr_wr = 1'b0; clr_mask = 2'b00; count = 8'd0;
        repeat (3) @(negedge clk);
        check2("R3", "no set without tick", flag, 2'b00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule